// File: doc/BRIEF.md
# Colour Lookup Unit with Split-Index Pixel Modes

The block converts a pixel word into 8-bit red, green and blue values through a 256-entry colour table of 24-bit entries. A host loads the table through a single 32-bit write port. A select code in the top nibble of each bus word picks one of two targets. The first is the write pointer, which takes a new position. The second is the colour data path, which stores a colour at the pointer and then moves the pointer on by one.

On the pixel side, a 3-bit depth code taken from the control word decides how the pixel is turned into table indices. Shallow depths use the low pixel bits as a single index, and that index serves all three channels. At 16 bits per pixel each channel is looked up with its own overlapping byte of the pixel. At 32 bits per pixel each channel is looked up with its own byte. Because the table is stored as three channel banks, the three channels can read three different entries in the same cycle. The colour outputs are registered and follow the pixel input by exactly one clock.

Top module: `clut_core`

## Requirements
- R1: Reset (`rst` high at a clock edge) returns the write pointer to entry 0, so the first colour write after reset lands in entry 0.
- R2: A bus write whose bits [31:28] equal 4'h1 loads the write pointer from bits [7:0]. The next colour write lands in that entry.
- R3: A bus write whose bits [31:28] equal 4'h2 stores bits [23:0] at the pointer, with red in [7:0], green in [15:8] and blue in [23:16]. The pointer then increments and wraps from 255 to 0.
- R4: A bus write with any other select code changes neither the pointer nor any table entry.
- R5: The colour outputs are registered. They reflect the pixel and depth code presented one clock earlier, and they read zero while reset is applied.
- R6: The depth code sits in `ctrl_word[7:5]` and all other control bits are ignored. Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel. In these modes the pixel's low 1, 2, 4 or 8 bits, zero-extended to 8 bits, index one entry that supplies all three channels.
- R7: Code 4 selects 16 bits per pixel. Red is looked up with pixel[7:0], green with pixel[11:4] and blue with pixel[15:8].
- R8: Code 6 selects 32 bits per pixel. Red is looked up with pixel[7:0], green with pixel[15:8] and blue with pixel[23:16].
- R9: The unused codes 5 and 7 behave as 8 bits per pixel.
- R10: When a colour write and a pixel read address the same entry in the same cycle, the output carries the entry's previous contents. The new colour appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_word | input | 32 | Bus word: select code in [31:28], payload in the low bits |
| ctrl_word | input | 32 | Control word; depth code in [7:5] |
| pix_word | input | 32 | Pixel to translate |
| red_o | output | 8 | Red channel, one cycle after the pixel |
| green_o | output | 8 | Green channel, one cycle after the pixel |
| blue_o | output | 8 | Blue channel, one cycle after the pixel |

## Verification
A pointer that drifts, skips or fails to wrap cannot be seen directly at the ports. It shows up one clock after a later pixel read, as a colour that belongs to a neighbouring entry. For that reason the checks fill every entry with channel values that differ from one another, and then read entries chosen so that an off-by-one store gives a visibly wrong triple. A wrong slice choice in the split modes shows one cycle after the pixel is presented, as a channel taken from the wrong entry. A read that bypasses a write in the same cycle shows in that same following cycle, as the new colour appearing one cycle too early.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int WORD_W   = 32;
    localparam int CHAN_W   = 8;
    localparam int N_CHAN   = 3;
    localparam int ENTRIES  = 256;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int SEL_W    = 4;
    localparam int SEL_LSB  = WORD_W - SEL_W;
    localparam int MODE_W   = 3;
    localparam int MODE_LSB = 5;
    localparam int COLOR_W  = N_CHAN * CHAN_W;

    localparam logic [SEL_W-1:0] SEL_POINTER = 4'h1;
    localparam logic [SEL_W-1:0] SEL_COLOUR  = 4'h2;

    typedef enum logic [MODE_W-1:0] {
        DEPTH_1   = 3'd0,
        DEPTH_2   = 3'd1,
        DEPTH_4   = 3'd2,
        DEPTH_8   = 3'd3,
        DEPTH_16  = 3'd4,
        DEPTH_RSV5 = 3'd5,
        DEPTH_32  = 3'd6,
        DEPTH_RSV7 = 3'd7
    } depth_e;

    typedef struct packed {
        logic [CHAN_W-1:0] b;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] r;
    } rgb_t;

    typedef struct packed {
        logic [IDX_W-1:0] b;
        logic [IDX_W-1:0] g;
        logic [IDX_W-1:0] r;
    } idx3_t;

    function automatic depth_e depth_of(input logic [WORD_W-1:0] ctrl);
        return depth_e'(ctrl[MODE_LSB +: MODE_W]);
    endfunction

    function automatic idx3_t shared_index(input logic [IDX_W-1:0] v);
        idx3_t t;
        t.r = v;
        t.g = v;
        t.b = v;
        return t;
    endfunction

    function automatic idx3_t pick_index(input depth_e d, input logic [WORD_W-1:0] p);
        idx3_t t;
        unique case (d)
            DEPTH_1:  t = shared_index({{(IDX_W-1){1'b0}}, p[0]});
            DEPTH_2:  t = shared_index({{(IDX_W-2){1'b0}}, p[1:0]});
            DEPTH_4:  t = shared_index({{(IDX_W-4){1'b0}}, p[3:0]});
            DEPTH_16: begin
                t.r = p[7:0];
                t.g = p[11:4];
                t.b = p[15:8];
            end
            DEPTH_32: begin
                t.r = p[7:0];
                t.g = p[15:8];
                t.b = p[23:16];
            end
            default:  t = shared_index(p[IDX_W-1:0]);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/clut_regport.sv
module clut_regport
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [IDX_W-1:0]  wr_ptr,
    output logic              store_en,
    output rgb_t              store_rgb
);

    logic [SEL_W-1:0] sel;
    logic             ptr_load;

    assign sel       = wr_word[SEL_LSB +: SEL_W];
    assign ptr_load  = wr_en && (sel == SEL_POINTER);
    assign store_en  = wr_en && (sel == SEL_COLOUR);
    assign store_rgb = rgb_t'(wr_word[COLOR_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (ptr_load) begin
            wr_ptr <= wr_word[IDX_W-1:0];
        end else if (store_en) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/clut_index_gen.sv
module clut_index_gen
    import clut_pkg::*;
(
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] pix_word,
    output idx3_t             rd_idx
);

    depth_e depth;

    always_comb begin
        depth  = depth_of(ctrl_word);
        rd_idx = pick_index(depth, pix_word);
    end

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/clut_core.sv
module clut_core
    import clut_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] pix_word,
    output logic [7:0]  red_o,
    output logic [7:0]  green_o,
    output logic [7:0]  blue_o
);

    logic [IDX_W-1:0] wr_ptr;
    logic             store_en;
    rgb_t             store_rgb;
    idx3_t            rd_idx;
    logic [COLOR_W-1:0] wdata_flat;
    logic [COLOR_W-1:0] raddr_flat;
    logic [COLOR_W-1:0] rdata_flat;
    rgb_t             out_rgb;

    clut_regport i_regport (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .wr_ptr    (wr_ptr),
        .store_en  (store_en),
        .store_rgb (store_rgb)
    );

    clut_index_gen i_index (
        .ctrl_word (ctrl_word),
        .pix_word  (pix_word),
        .rd_idx    (rd_idx)
    );

    assign wdata_flat = store_rgb;
    assign raddr_flat = rd_idx;

    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
        clut_bank #(
            .DEPTH (ENTRIES),
            .W     (CHAN_W)
        ) i_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (store_en),
            .waddr (wr_ptr),
            .wdata (wdata_flat[ch*CHAN_W +: CHAN_W]),
            .raddr (raddr_flat[ch*IDX_W +: IDX_W]),
            .rdata (rdata_flat[ch*CHAN_W +: CHAN_W])
        );
    end

    assign out_rgb = rgb_t'(rdata_flat);
    assign red_o   = out_rgb.r;
    assign green_o = out_rgb.g;
    assign blue_o  = out_rgb.b;

endmodule

// File: rtl/clut_checker.sv
module clut_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_word,
    input logic [7:0]  wr_ptr
);

    a_r1_ptr_cleared: assert property (@(posedge clk)
        rst |=> (wr_ptr == 8'd0));

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word[31:28] == 4'h1) |=> (wr_ptr == $past(wr_word[7:0])));

    a_r3_ptr_advance: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word[31:28] == 4'h2) |=> (wr_ptr == 8'($past(wr_ptr) + 8'd1)));

    a_r4_ptr_untouched: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || (wr_word[31:28] != 4'h1 && wr_word[31:28] != 4'h2)) |=> $stable(wr_ptr));

endmodule

bind clut_core clut_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_ptr  (wr_ptr)
);

// File: tb/test_clut_core.sv
module test_clut_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] pix_word = '0;
    logic [7:0]  red_o, green_o, blue_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];

    clut_core i_clut_core (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .ctrl_word (ctrl_word),
        .pix_word  (pix_word),
        .red_o     (red_o),
        .green_o   (green_o),
        .blue_o    (blue_o)
    );

    always #4 clk = ~clk;

    // {mode[2:0], pixel[31:0], red idx, green idx, blue idx}
    localparam logic [58:0] VEC [0:10] = '{
        {3'd0, 32'hFFFF_FFFF, 8'h01, 8'h01, 8'h01},
        {3'd0, 32'hFFFF_FFFE, 8'h00, 8'h00, 8'h00},
        {3'd1, 32'h0000_00F6, 8'h02, 8'h02, 8'h02},
        {3'd2, 32'h1234_567B, 8'h0B, 8'h0B, 8'h0B},
        {3'd3, 32'h1234_56C7, 8'hC7, 8'hC7, 8'hC7},
        {3'd4, 32'h0000_ABCD, 8'hCD, 8'hBC, 8'hAB},
        {3'd4, 32'hFFFF_1234, 8'h34, 8'h23, 8'h12},
        {3'd6, 32'h003C_5A96, 8'h96, 8'h5A, 8'h3C},
        {3'd6, 32'hFF01_80FF, 8'hFF, 8'h80, 8'h01},
        {3'd5, 32'h0000_0F42, 8'h42, 8'h42, 8'h42},
        {3'd7, 32'h1111_11E0, 8'hE0, 8'hE0, 8'hE0}
    };

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [3:0] sel, input logic [23:0] payload);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_word = {sel, 4'h0, payload};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_word = '0;
    endtask

    task automatic store(input logic [7:0] idx, input logic [23:0] c);
        bus(4'h2, c);
        m_r[idx] = c[7:0];
        m_g[idx] = c[15:8];
        m_b[idx] = c[23:16];
    endtask

    task automatic look(input logic [2:0] mode, input logic [31:0] pix);
        @(negedge clk);
        ctrl_word = 32'hFFFF_FF1F | ({29'd0, mode} << 5);
        pix_word  = pix;
        @(negedge clk);
    endtask

    function automatic logic [23:0] expect3(input logic [7:0] ri, input logic [7:0] gi, input logic [7:0] bi);
        return {m_b[bi], m_g[gi], m_r[ri]};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: outputs read zero during reset
        check("R5 reset outputs", {blue_o, green_o, red_o}, 24'h0);
        rst = 1'b0;

        // R1: fill without a pointer write, starting at entry 0
        for (int i = 0; i < 256; i++) begin
            store(8'(i), {8'(i * 7 + 3), 8'(i) ^ 8'hA5, 8'(i)});
        end
        look(3'd3, 32'h0000_0000);
        check("R1 first store at entry 0", {blue_o, green_o, red_o}, 24'h03A5_00);

        // R6..R9 table walk
        for (int k = 0; k < 11; k++) begin
            logic [58:0] v;
            string req;
            v = VEC[k];
            look(v[58:56], v[55:24]);
            if (v[58:56] <= 3'd3) req = "R6";
            else if (v[58:56] == 3'd4) req = "R7";
            else if (v[58:56] == 3'd6) req = "R8";
            else req = "R9";
            check(req, {blue_o, green_o, red_o}, expect3(v[23:16], v[15:8], v[7:0]));
        end

        // R3: pointer wrapped to 0 after 256 stores
        store(8'h00, 24'h123456);
        look(3'd3, 32'h0);
        check("R3 wrap to entry 0", {blue_o, green_o, red_o}, 24'h123456);

        // R2: pointer load then store
        bus(4'h1, 24'h0000_9C);
        store(8'h9C, 24'hABCDEF);
        look(3'd3, 32'h9C);
        check("R2 store after pointer load", {blue_o, green_o, red_o}, 24'hABCDEF);
        // R3: pointer advanced to 9D
        store(8'h9D, 24'h0F1E2D);
        look(3'd3, 32'h9D);
        check("R3 increment", {blue_o, green_o, red_o}, 24'h0F1E2D);

        // R4: other select codes ignored
        bus(4'h1, 24'h0000_20);
        bus(4'h0, 24'h000077);
        bus(4'hF, 24'hEEEE77);
        bus(4'h3, 24'h000055);
        store(8'h20, 24'h445566);
        look(3'd3, 32'h20);
        check("R4 pointer kept", {blue_o, green_o, red_o}, 24'h445566);
        look(3'd3, 32'h21);
        check("R4 neighbour kept", {blue_o, green_o, red_o}, expect3(8'h21, 8'h21, 8'h21));
        look(3'd3, 32'h77);
        check("R4 payload entry kept", {blue_o, green_o, red_o}, expect3(8'h77, 8'h77, 8'h77));

        // R10 and R5: same-cycle write and read
        bus(4'h1, 24'h0000_10);
        @(negedge clk);
        ctrl_word = 32'h0000_0060;
        pix_word  = 32'h10;
        wr_en     = 1'b1;
        wr_word   = {4'h2, 4'h0, 24'h998877};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_word = '0;
        check("R10 old value on collision", {blue_o, green_o, red_o}, expect3(8'h10, 8'h10, 8'h10));
        m_r[8'h10] = 8'h77; m_g[8'h10] = 8'h88; m_b[8'h10] = 8'h99;
        @(negedge clk);
        check("R10 new value next cycle", {blue_o, green_o, red_o}, 24'h998877);

        // R5: one-cycle latency
        @(negedge clk);
        pix_word = 32'h11;
        @(posedge clk);
        #1;
        check("R5 latency", {blue_o, green_o, red_o}, expect3(8'h11, 8'h11, 8'h11));

        // R1: reset mid-run clears pointer
        bus(4'h1, 24'h0000_40);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        store(8'h00, 24'h5A5A01);
        look(3'd3, 32'h0);
        check("R1 reset pointer", {blue_o, green_o, red_o}, 24'h5A5A01);
        look(3'd3, 32'h40);
        check("R1 entry 40 unchanged", {blue_o, green_o, red_o}, expect3(8'h40, 8'h40, 8'h40));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule